// File: doc/BRIEF.md
# HDLC Masked Address Filter

This block sits in the receive path of an HDLC link, after bit-level framing and before the receive FIFO. It watches the byte stream and reads the leading address of every packet, where a packet starts at a byte flagged as start-of-frame. It then decides whether to keep the packet. Kept packets are passed on unchanged and in order. Dropped packets produce no output bytes at all, so the FIFO never sees them. Alongside the stream it presents an accept/drop flag that stays valid until the next packet starts.

A single 32-bit value register and a 32-bit mask register hold the candidate addresses. A 2-bit mode decides how they are used. In one mode they are four independent one-byte addresses. In another they are two two-byte addresses. In the remaining modes the filter is off and every packet is accepted. A mask bit of 1 means that address bit must agree with the value bit. A packet is kept when any candidate agrees on all of its compared bits.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While reset is held, `out_valid` and `dec_valid` are low.
- R2: If `cfg_mode` is 2'b00 or 2'b11 when a start-of-frame byte arrives, that packet is accepted. In the cycle after that byte, `dec_valid` = 1 and `dec_accept` = 1.
- R3: Mode 2'b01 is one-byte matching. Candidate i (i = 0..3) uses value bits [8i+7:8i] and mask bits [8i+7:8i]. The first byte of the packet matches candidate i when every bit whose mask bit is 1 equals the value bit. The packet is accepted when any candidate matches. The decision shows on `dec_valid`/`dec_accept` in the cycle after the first byte.
- R4: Mode 2'b10 is two-byte matching. Candidate j (j = 0..1) uses bits [16j+15:16j] of the value and mask registers. The first received byte is compared with the low byte of the candidate and the second byte with the high byte. `dec_valid` is low in the cycle after the first byte. The decision shows in the cycle after the second byte.
- R5: Every byte of an accepted packet appears on `out_data` exactly once, in arrival order, at most one byte per cycle. `out_sof` is high only with the first byte of the packet. Order is kept across packet boundaries.
- R6: A dropped packet produces no `out_valid` cycle for any of its bytes.
- R7: Once `dec_valid` is high, it and `dec_accept` keep their values until the next start-of-frame byte.
- R8: In two-byte mode, a packet that ends after a single byte produces no output bytes and no decision.
- R9: The mode is taken from the start-of-frame byte's cycle only. A later change of `cfg_mode` within the packet does not alter that packet's decision or forwarding.
- R10: Bytes that arrive after reset and before any start-of-frame are dropped. `in_sof` with `in_valid` low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 00/11 off, 01 one-byte, 10 two-byte matching |
| cfg_match | input | 32 | Candidate address values |
| cfg_mask | input | 32 | Compare enables, 1 = bit compared |
| in_valid | input | 1 | Received byte present |
| in_sof | input | 1 | Byte is the first of a packet (with in_valid) |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Forwarded byte present |
| out_sof | output | 1 | Forwarded byte is first of its packet |
| out_data | output | 8 | Forwarded byte |
| dec_valid | output | 1 | Decision for current packet available |
| dec_accept | output | 1 | 1 = accepted, 0 = dropped |

## Verification
One-byte patterns are chosen to hit each of the four candidates in turn. One of them agrees only under a partial mask, and one hits no candidate at all, so each byte lane and the mask gating are exercised separately. Two-byte patterns include the correct address and the same two bytes swapped. They also include an address that fails only in its second byte and one that hits the second candidate through a low byte that is not compared. Together these separate the byte order from the lane choice. Packets are sent back to back and with idle gaps, which exercises the one-byte holding path at packet boundaries. Some cases change the mode in the middle of a packet, and some assert start-of-frame without a valid byte.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ONE  = 2'b01,
        MODE_TWO  = 2'b10,
        MODE_OFFX = 2'b11
    } af_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_PASS = 2'b10,
        ST_DROP = 2'b11
    } af_state_e;

    // one byte slot: rel = released for output, otherwise held pending a decision
    typedef struct packed {
        logic              vld;
        logic              rel;
        logic              sof;
        logic [BYTE_W-1:0] data;
    } af_slot_t;

    typedef struct packed {
        af_state_e st;
        af_slot_t  pend;
        af_slot_t  outs;
        logic      dec_v;
        logic      dec_a;
    } af_regs_t;

endpackage

// File: rtl/hdlc_af_mode_dec.sv
module hdlc_af_mode_dec
    import hdlc_af_pkg::*;
(
    input  logic [1:0] mode,
    output logic       match_en,
    output logic       two_byte
);
    af_mode_e m;

    always_comb begin
        m        = af_mode_e'(mode);
        match_en = 1'b0;
        two_byte = 1'b0;
        case (m)
            MODE_ONE: match_en = 1'b1;
            MODE_TWO: begin
                match_en = 1'b1;
                two_byte = 1'b1;
            end
            default:  match_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/hdlc_af_cmp1.sv
module hdlc_af_cmp1
    import hdlc_af_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [BYTE_W-1:0] first,
    input  logic [CFG_W-1:0]  match,
    input  logic [CFG_W-1:0]  mask,
    output logic              hit
);
    localparam int NCAND = CFG_W / BYTE_W;

    logic [NCAND-1:0] lane_hit;

    for (genvar i = 0; i < NCAND; i++) begin : g_lane
        assign lane_hit[i] =
            ((first ^ match[i*BYTE_W +: BYTE_W]) & mask[i*BYTE_W +: BYTE_W]) == '0;
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/hdlc_af_cmp2.sv
module hdlc_af_cmp2
    import hdlc_af_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [BYTE_W-1:0] first,
    input  logic [BYTE_W-1:0] second,
    input  logic [CFG_W-1:0]  match,
    input  logic [CFG_W-1:0]  mask,
    output logic              hit
);
    localparam int HW_W  = 2 * BYTE_W;
    localparam int NCAND = CFG_W / HW_W;

    logic [NCAND-1:0] lane_hit;
    logic [HW_W-1:0]  addr;

    assign addr = {second, first};

    for (genvar j = 0; j < NCAND; j++) begin : g_lane
        assign lane_hit[j] =
            ((addr ^ match[j*HW_W +: HW_W]) & mask[j*HW_W +: HW_W]) == '0;
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_af_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [CFG_W-1:0]  cfg_match,
    input  logic [CFG_W-1:0]  cfg_mask,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic [BYTE_W-1:0] out_data,
    output logic              dec_valid,
    output logic              dec_accept
);
    af_regs_t r_q, r_d;

    logic match_en, two_byte;
    logic hit_one, hit_two;

    hdlc_af_mode_dec u_mode (
        .mode     (cfg_mode),
        .match_en (match_en),
        .two_byte (two_byte)
    );

    hdlc_af_cmp1 #(.CFG_W(CFG_W)) u_cmp1 (
        .first (in_data),
        .match (cfg_match),
        .mask  (cfg_mask),
        .hit   (hit_one)
    );

    hdlc_af_cmp2 #(.CFG_W(CFG_W)) u_cmp2 (
        .first  (r_q.pend.data),
        .second (in_data),
        .match  (cfg_match),
        .mask   (cfg_mask),
        .hit    (hit_two)
    );

    logic sof_byte;
    logic slot_busy;
    logic emit_req;
    logic emit_sof;

    assign sof_byte = in_valid & in_sof;

    always_comb begin
        r_d       = r_q;
        r_d.outs  = '0;
        slot_busy = 1'b0;
        emit_req  = 1'b0;
        emit_sof  = 1'b0;

        // a released byte waiting in the pending slot goes out first
        if (r_q.pend.vld && r_q.pend.rel) begin
            r_d.outs  = r_q.pend;
            r_d.pend  = '0;
            slot_busy = 1'b1;
        end

        if (sof_byte) begin
            r_d.dec_v = 1'b0;
            r_d.dec_a = 1'b0;
            if (r_q.pend.vld && !r_q.pend.rel) begin
                r_d.pend = '0;   // unfinished two-byte address: discarded
            end
            if (!match_en) begin
                r_d.dec_v = 1'b1;
                r_d.dec_a = 1'b1;
                r_d.st    = ST_PASS;
                emit_req  = 1'b1;
                emit_sof  = 1'b1;
            end else if (!two_byte) begin
                r_d.dec_v = 1'b1;
                r_d.dec_a = hit_one;
                r_d.st    = hit_one ? ST_PASS : ST_DROP;
                emit_req  = hit_one;
                emit_sof  = 1'b1;
            end else begin
                r_d.st   = ST_WAIT;
                r_d.pend = '{vld: 1'b1, rel: 1'b0, sof: 1'b1, data: in_data};
            end
        end else if (in_valid) begin
            case (r_q.st)
                ST_PASS: emit_req = 1'b1;
                ST_WAIT: begin
                    r_d.dec_v = 1'b1;
                    r_d.dec_a = hit_two;
                    if (hit_two) begin
                        r_d.st   = ST_PASS;
                        r_d.outs = '{vld: 1'b1, rel: 1'b1, sof: r_q.pend.sof,
                                     data: r_q.pend.data};
                        r_d.pend = '{vld: 1'b1, rel: 1'b1, sof: 1'b0, data: in_data};
                    end else begin
                        r_d.st   = ST_DROP;
                        r_d.pend = '0;
                    end
                end
                default: ;
            endcase
        end

        if (emit_req) begin
            if (slot_busy) begin
                r_d.pend = '{vld: 1'b1, rel: 1'b1, sof: emit_sof, data: in_data};
            end else begin
                r_d.outs = '{vld: 1'b1, rel: 1'b1, sof: emit_sof, data: in_data};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid  = r_q.outs.vld;
    assign out_sof    = r_q.outs.vld & r_q.outs.sof;
    assign out_data   = r_q.outs.data;
    assign dec_valid  = r_q.dec_v;
    assign dec_accept = r_q.dec_a;

endmodule

// File: rtl/hdlc_af_chk.sv
module hdlc_af_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       in_valid,
    input logic       in_sof,
    input logic       out_valid,
    input logic       dec_valid,
    input logic       dec_accept
);
    // R2
    p_off_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && (cfg_mode == 2'b00 || cfg_mode == 2'b11))
        |=> (dec_valid && dec_accept));

    // R4
    p_two_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && cfg_mode == 2'b10) |=> !dec_valid);

    // R7
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !(in_valid && in_sof)) |=> (dec_valid && $stable(dec_accept)));

    // R10
    p_lone_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sof && !in_valid && dec_valid) |=> dec_valid);

    // R6
    p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept && $past(dec_valid && !dec_accept)) |-> !out_valid);
endmodule

bind hdlc_addr_filter hdlc_af_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .out_valid  (out_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
);

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [31:0] cfg_match = '0;
    logic [31:0] cfg_mask = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_sof, dec_valid, dec_accept;
    logic [7:0]  out_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [8:0] exp_q [$];

    always #2 clk = ~clk;

    hdlc_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_match(cfg_match),
        .cfg_mask(cfg_mask), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare every forwarded byte (R5, R6)
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected byte", {out_sof, out_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({out_sof, out_data} == e, "R5", "forwarded byte",
                    {out_sof, out_data}, e);
            end
        end
    end

    function automatic bit exp_acc(input logic [1:0] m, input logic [7:0] b0,
                                   input logic [7:0] b1, input int len);
        if (m == 2'b01) begin
            for (int i = 0; i < 4; i++)
                if (((b0 ^ cfg_match[8*i +: 8]) & cfg_mask[8*i +: 8]) == 8'h00) return 1'b1;
            return 1'b0;
        end else if (m == 2'b10) begin
            if (len < 2) return 1'b0;
            for (int j = 0; j < 2; j++)
                if ((({b1, b0} ^ cfg_match[16*j +: 16]) & cfg_mask[16*j +: 16]) == 16'h0)
                    return 1'b1;
            return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
    endtask

    task automatic send_raw(input logic v, input logic s, input logic [7:0] d);
        @(negedge clk);
        in_valid = v;
        in_sof   = s;
        in_data  = d;
    endtask

    // driver: pushes expected bytes, drives the packet, checks the decision
    task automatic send_pkt(input logic [1:0] m, input int mid_mode,
                            input logic [7:0] p [8], input int len, input int gap,
                            input string req);
        bit acc;
        int dix;
        acc = exp_acc(m, p[0], p[1], len);
        dix = (m == 2'b10) ? 1 : 0;
        if (acc) begin
            for (int i = 0; i < len; i++) exp_q.push_back({(i == 0), p[i]});
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_data  = p[i];
            if (i == 0) cfg_mode = m;
            if (i == 1 && mid_mode >= 0) cfg_mode = mid_mode[1:0];
            if (i == 0 && m == 2'b10) begin
                @(posedge clk); #1;
                chk(dec_valid == 1'b0, "R4", "no decision after first byte", dec_valid, 0);
            end
            if (i == dix) begin
                @(posedge clk); #1;
                chk(dec_valid == 1'b1, req, "dec_valid", dec_valid, 1);
                chk(dec_accept == acc, req, "dec_accept", dec_accept, acc);
            end
            if (gap > 0) idle(gap);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pk [8];
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(dec_valid == 1'b0, "R1", "dec_valid in reset", dec_valid, 0);
        rst_n = 1'b1;

        // R10: bytes before any start-of-frame are dropped
        send_raw(1'b1, 1'b0, 8'h11);
        send_raw(1'b1, 1'b0, 8'h22);
        idle(4);
        chk(dec_valid == 1'b0, "R10", "no decision before sof", dec_valid, 0);

        // R2: filter off in both encodings
        pk = '{8'hA5, 8'h01, 8'h02, 0, 0, 0, 0, 0};
        send_pkt(2'b00, -1, pk, 3, 0, "R2");
        pk = '{8'h5A, 8'h03, 0, 0, 0, 0, 0, 0};
        send_pkt(2'b11, -1, pk, 2, 1, "R2");
        idle(3);

        // R3: one-byte candidates
        cfg_match = 32'h7E40_03C1;
        cfg_mask  = 32'hFFF0_FFFF;
        pk = '{8'hC1, 8'h10, 8'h20, 0, 0, 0, 0, 0};
        send_pkt(2'b01, -1, pk, 3, 0, "R3");
        pk = '{8'h03, 8'h30, 0, 0, 0, 0, 0, 0};
        send_pkt(2'b01, -1, pk, 2, 0, "R3");
        pk = '{8'h4A, 8'h31, 8'h32, 0, 0, 0, 0, 0};
        send_pkt(2'b01, -1, pk, 3, 2, "R3");
        pk = '{8'h55, 8'h41, 8'h42, 0, 0, 0, 0, 0};
        send_pkt(2'b01, -1, pk, 3, 0, "R6");
        idle(5);
        chk(dec_valid == 1'b1 && dec_accept == 1'b0, "R7", "drop decision held",
            {dec_valid, dec_accept}, 2);
        pk = '{8'h7E, 8'h51, 0, 0, 0, 0, 0, 0};
        send_pkt(2'b01, -1, pk, 2, 0, "R3");
        idle(6);
        chk(dec_valid == 1'b1 && dec_accept == 1'b1, "R7", "accept decision held",
            {dec_valid, dec_accept}, 3);

        // R10: start-of-frame without a valid byte inside a kept packet
        send_raw(1'b0, 1'b1, 8'h00);
        @(posedge clk); #1;
        chk(dec_valid == 1'b1 && dec_accept == 1'b1, "R10", "lone sof ignored",
            {dec_valid, dec_accept}, 3);
        exp_q.push_back({1'b0, 8'h77});
        send_raw(1'b1, 1'b0, 8'h77);
        idle(3);

        // R4: two-byte candidates
        cfg_match = 32'h0800_BEEF;
        cfg_mask  = 32'hFF00_FFFF;
        pk = '{8'hEF, 8'hBE, 8'h61, 8'h62, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 4, 0, "R4");
        pk = '{8'hBE, 8'hEF, 8'h63, 0, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 3, 0, "R6");
        pk = '{8'h33, 8'h08, 8'h64, 0, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 3, 1, "R4");
        pk = '{8'hEF, 8'hBF, 8'h65, 0, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 3, 0, "R6");
        pk = '{8'hEF, 8'hBE, 0, 0, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 2, 0, "R4");
        idle(3);

        // R8: single-byte packet in two-byte mode, then a kept packet
        pk = '{8'hEF, 0, 0, 0, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 1, 0, "R8");
        pk = '{8'hEF, 8'hBE, 8'h71, 0, 0, 0, 0, 0};
        send_pkt(2'b10, -1, pk, 3, 0, "R8");
        idle(3);

        // R9: mode changed within a packet
        cfg_match = 32'h7E40_03C1;
        cfg_mask  = 32'hFFF0_FFFF;
        pk = '{8'hC1, 8'h81, 8'h82, 0, 0, 0, 0, 0};
        send_pkt(2'b01, 2, pk, 3, 0, "R9");
        cfg_match = 32'h0800_BEEF;
        cfg_mask  = 32'hFF00_FFFF;
        pk = '{8'hBE, 8'hEF, 8'h83, 0, 0, 0, 0, 0};
        send_pkt(2'b10, 0, pk, 3, 0, "R9");
        idle(5);
        chk(dec_valid == 1'b1 && dec_accept == 1'b0, "R9", "mid-packet mode ignored",
            {dec_valid, dec_accept}, 2);

        idle(6);
        chk(exp_q.size() == 0, "R5", "all expected bytes seen", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule